// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Sequencer

This block turns per-phase commands into six gate enables for a three-phase bridge, one high-side and one low-side enable for each phase. The high-side command of each phase is active-low. When dead time is in force, the low-side command of a phase wins over its high-side command. Every turn-on of an enable waits a programmable number of clock cycles. Every turn-off takes effect at the first edge that sees the change.

A halt input and an undervoltage lockout flag each force all six enables off. A bypass input removes both the dead time and the low-side priority, so the enables follow the commands. In bypass, the two enables of a phase may be on together. After reset, a refresh interval keeps all low-side enables on and all high-side enables off so that the bootstrap supplies can charge. Normal command control begins only when this interval ends.

All inputs pass through a two-stage synchronizer. The enables come straight from registers.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it is released, all six enables are 0.
- R2: After reset release, a refresh interval of RFSH_BASE+RFSH_EXT clock edges runs. During it, every lo_gate bit is 1 and every hi_gate bit is 0, unless halt or uv_lock is high. At the next edge, normal control begins, and lo_gate bits whose lo_cmd is 0 fall.
- R3: hi_cmd_n bit x = 0 requests hi_gate bit x on, and bit x = 1 requests it off. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C, for every vector port.
- R4: With dt_bypass low, lo_cmd bit x = 1 forces hi_gate bit x off. hi_gate bit x and lo_gate bit x are never both 1.
- R5: With dt_bypass low, an enable turns on at the (DEAD_CYC+2)-th rising edge after its request appears on the pins: two synchronizer edges plus DEAD_CYC edges of count.
- R6: If a request drops before its count completes, the count restarts from zero when the request returns.
- R7: An enable whose request is withdrawn turns off at the 3rd edge after the pin change.
- R8: halt = 1 drives all six enables to 0 at the 3rd edge. It overrides the commands, bypass and the refresh interval.
- R9: uv_lock = 1 drives all six enables to 0 at the 3rd edge.
- R10: After halt or uv_lock is released, a still-requested enable returns only after a full dead-time count, at the (DEAD_CYC+2)-th edge.
- R11: With dt_bypass high, each enable equals its raw request at the 3rd edge, with no count and no low-side priority. Both enables of a phase may then be 1 together.
- R12: The phases are independent. A command on one phase leaves the enables of the other phases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd_n | input | NPH | Active-low high-side commands, bit 0 = phase A |
| lo_cmd | input | NPH | Active-high low-side commands |
| halt | input | 1 | Forces all enables off |
| uv_lock | input | 1 | Undervoltage lockout flag, forces all enables off |
| dt_bypass | input | 1 | Removes dead time and low-side priority |
| hi_gate | output | NPH | High-side gate enables |
| lo_gate | output | NPH | Low-side gate enables |

## Verification
Two functions can act in the same cycle: the dead-time count reaching its end, and halt taking hold. The bench starts a high-side request, then raises halt three edges later. The synchronized halt therefore arrives on exactly the edge where the count would have switched the enable on. The result is correct only if that high-side enable never shows a 1 at that edge and every other enable is also 0. A second collision is also checked: a low-side command arriving while a high-side enable is already on must remove the high-side enable before the low-side enable can rise.

// File: rtl/bgc_pkg.sv
// Package: shared constants and types for the bridge gate sequencer.
// Assumes bit order A=0, B=1, C=2 on every per-phase vector.
package bgc_pkg;
    localparam int unsigned BGC_PHASES = 3;
    localparam int unsigned BGC_SYNC_STAGES = 2;

    // Pair of gate enables for one phase.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;
endpackage

// File: rtl/bgc_sync.sv
// Module: multi-stage synchronizer for a bus of independent level inputs.
// Assumes each bit is a slow level; no bus coherence is implied.
// The reset value is a parameter so that every input resets to its safe level.
module bgc_sync #(
    parameter int unsigned W      = 9,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bgc_refresh.sv
// Module: start-up refresh sequencer.
// Holds 'active' high for LEN edges after reset release, then drops it
// and never raises it again until the next reset.
module bgc_refresh #(
    parameter int unsigned LEN = 188
) (
    input  logic clk,
    input  logic rst_n,
    output logic active
);
    localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Count refresh edges and end the interval on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LEN - 1)) active <= 1'b0;
        end
    end

    // R2: once ended, the refresh interval never restarts.
    p_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);
endmodule

// File: rtl/bgc_ontimer.sv
// Module: one gate enable with a turn-on delay and an immediate turn-off.
// Priority: blk > force_on > byp > request/count.
// Assumes req, blk, byp and force_on are synchronized levels.
module bgc_ontimer #(
    parameter int unsigned DT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic blk,
    input  logic byp,
    input  logic force_on,
    output logic gate
);
    localparam int unsigned CW = (DT < 2) ? 1 : $clog2(DT + 1);

    logic [CW-1:0] cnt;

    // Resolve the priorities and run the dead-time count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (blk) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (force_on) begin
            gate <= 1'b1;
            cnt  <= '0;
        end else if (byp) begin
            gate <= req;
            cnt  <= '0;
        end else if (!req) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (!gate) begin
            if (cnt == CW'(DT - 1)) begin
                gate <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Checker: independent run length of an unbroken, countable request.
    logic [CW-1:0] held;
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (req && !blk && !byp && !force_on)
            held <= (held == CW'(DT)) ? held : held + 1'b1;
        else
            held <= '0;
    end

    // R5 / R6: a counted turn-on needs DEAD_CYC unbroken request edges.
    p_onset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate) && $past(!byp && !force_on)) |-> ($past(held) >= CW'(DT - 1)));

    // R7: a withdrawn request turns the enable off at the next edge.
    p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !byp && !force_on) |=> !gate);

    // R8 / R9: a block drives the enable off at the next edge.
    p_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> !gate);
endmodule

// File: rtl/bgc_phase.sv
// Module: one half-bridge phase.
// Decodes the active-low high-side command, applies low-side priority
// unless bypass is on, and drives two on-timers.
module bgc_phase
    import bgc_pkg::*;
#(
    parameter int unsigned DT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_n,
    input  logic       lo,
    input  logic       blk,
    input  logic       byp,
    input  logic       rfsh,
    output gate_pair_t gates
);
    logic hi_req;
    logic hi_blk;

    // High request: inverted command, masked by the low command unless bypassed.
    always_comb begin
        hi_req = !hi_n && (byp || !lo);
        hi_blk = blk || rfsh;
    end

    bgc_ontimer #(.DT(DT)) u_hi (
        .clk(clk), .rst_n(rst_n), .req(hi_req), .blk(hi_blk),
        .byp(byp), .force_on(1'b0), .gate(gates.hi)
    );

    bgc_ontimer #(.DT(DT)) u_lo (
        .clk(clk), .rst_n(rst_n), .req(lo), .blk(blk),
        .byp(byp), .force_on(rfsh), .gate(gates.lo)
    );

    // R4: with dead time in force, the two enables of a phase are never both on.
    p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !byp |=> !(gates.hi && gates.lo));

    // R2: during refresh, low on and high off unless blocked.
    p_rfsh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh && !blk) |=> (gates.lo && !gates.hi));
endmodule

// File: rtl/bridge_gate_ctrl.sv
// Module: top of the three-phase gate sequencer.
// Synchronizes all command inputs, runs the start-up refresh and one
// phase slice per phase. Reset drives every enable off.
// Timing parameters are given in clock cycles.
module bridge_gate_ctrl
    import bgc_pkg::*;
#(
    parameter int unsigned NPH       = BGC_PHASES,
    parameter int unsigned DEAD_CYC  = 4,
    parameter int unsigned RFSH_BASE = 188,
    parameter int unsigned RFSH_EXT  = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hi_cmd_n,
    input  logic [NPH-1:0] lo_cmd,
    input  logic           halt,
    input  logic           uv_lock,
    input  logic           dt_bypass,
    output logic [NPH-1:0] hi_gate,
    output logic [NPH-1:0] lo_gate
);
    localparam int unsigned DT_EFF   = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int unsigned RFSH_LEN = RFSH_BASE + RFSH_EXT;
    localparam int unsigned SW       = 2 * NPH + 3;
    // Safe reset levels: bypass off, lockout on, halt on, low off, high off (1).
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {NPH{1'b0}}, {NPH{1'b1}}};

    logic [SW-1:0]  sync_q;
    logic [NPH-1:0] hi_n_s;
    logic [NPH-1:0] lo_s;
    logic           halt_s;
    logic           uv_s;
    logic           byp_s;
    logic           blk;
    logic           rfsh;

    bgc_sync #(.W(SW), .STAGES(BGC_SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({dt_bypass, uv_lock, halt, lo_cmd, hi_cmd_n}),
        .q(sync_q)
    );

    // Split the synchronized bus and form the global block.
    always_comb begin
        {byp_s, uv_s, halt_s, lo_s, hi_n_s} = sync_q;
        blk = halt_s || uv_s;
    end

    bgc_refresh #(.LEN(RFSH_LEN)) u_rfsh (
        .clk(clk), .rst_n(rst_n), .active(rfsh)
    );

    for (genvar p = 0; p < int'(NPH); p++) begin : g_ph
        gate_pair_t gp;
        bgc_phase #(.DT(DT_EFF)) u_ph (
            .clk(clk), .rst_n(rst_n), .hi_n(hi_n_s[p]), .lo(lo_s[p]),
            .blk(blk), .byp(byp_s), .rfsh(rfsh), .gates(gp)
        );
        assign hi_gate[p] = gp.hi;
        assign lo_gate[p] = gp.lo;
    end

    // R8: a synchronized halt clears every enable at the next edge.
    p_halt_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_s |=> (hi_gate == '0 && lo_gate == '0));

    // R9: a synchronized lockout clears every enable at the next edge.
    p_uv_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (hi_gate == '0 && lo_gate == '0));
endmodule

// File: tb/sim_bridge_gate_ctrl.sv
module sim_bridge_gate_ctrl;
    localparam int unsigned NPH  = 3;
    localparam int unsigned DT   = 4;
    localparam int unsigned RLEN = 200;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] hi_cmd_n = 3'b000;
    logic [NPH-1:0] lo_cmd = 3'b000;
    logic           halt = 1'b0;
    logic           uv_lock = 1'b0;
    logic           dt_bypass = 1'b0;
    logic [NPH-1:0] hi_gate;
    logic [NPH-1:0] lo_gate;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bridge_gate_ctrl #(.NPH(NPH), .DEAD_CYC(DT), .RFSH_BASE(188), .RFSH_EXT(12)) u0 (
        .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd(lo_cmd),
        .halt(halt), .uv_lock(uv_lock), .dt_bypass(dt_bypass),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    // Advance n rising edges, then settle at the falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [NPH-1:0] hi_e, input logic [NPH-1:0] lo_e);
        n_chk++;
        if (hi_gate !== hi_e || lo_gate !== lo_e) begin
            n_bad++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_gate, lo_gate, hi_e, lo_e);
        end
    endtask

    task automatic t_reset_refresh();
        tick(3);
        chk("R1 in reset", 3'b000, 3'b000);
        rst_n = 1'b1;
        tick(1);
        chk("R1 first edge", 3'b000, 3'b000);
        tick(RLEN - 1);
        chk("R2 refresh last edge", 3'b000, 3'b111);
        tick(1);
        chk("R2 refresh ended", 3'b000, 3'b000);
        tick(DT - 2);
        chk("R5 hi not yet after refresh", 3'b000, 3'b000);
        tick(1);
        chk("R3 active-low hi on", 3'b111, 3'b000);
    endtask

    task automatic t_lo_priority();
        lo_cmd = 3'b001;
        tick(2);
        chk("R7 before turn-off edge", 3'b111, 3'b000);
        tick(1);
        chk("R4 lo overrides hi A, R12 B C kept", 3'b110, 3'b000);
        tick(2);
        chk("R5 lo A still counting", 3'b110, 3'b000);
        tick(1);
        chk("R4 lo A on after dead time", 3'b110, 3'b001);
        lo_cmd = 3'b000;
        tick(3);
        chk("R7 lo A off", 3'b110, 3'b000);
        tick(2);
        chk("R5 hi A not yet", 3'b110, 3'b000);
        tick(1);
        chk("R5 hi A back", 3'b111, 3'b000);
    endtask

    task automatic t_restart();
        hi_cmd_n = 3'b111;
        tick(3);
        chk("R3 high command releases hi", 3'b000, 3'b000);
        hi_cmd_n = 3'b110;
        tick(2);
        hi_cmd_n = 3'b111;
        tick(1);
        hi_cmd_n = 3'b110;
        tick(DT + 1);
        chk("R6 count restarted", 3'b000, 3'b000);
        tick(1);
        chk("R6 on after full count", 3'b001, 3'b000);
    endtask

    task automatic t_halt_uv();
        lo_cmd = 3'b100;
        tick(DT + 2);
        chk("R12 lo C with hi A", 3'b001, 3'b100);
        halt = 1'b1;
        tick(2);
        chk("R8 halt not yet", 3'b001, 3'b100);
        tick(1);
        chk("R8 halt clears all", 3'b000, 3'b000);
        halt = 1'b0;
        tick(DT + 1);
        chk("R10 halt release still waiting", 3'b000, 3'b000);
        tick(1);
        chk("R10 halt release restore", 3'b001, 3'b100);
        uv_lock = 1'b1;
        tick(3);
        chk("R9 lockout clears all", 3'b000, 3'b000);
        uv_lock = 1'b0;
        tick(DT + 1);
        chk("R10 lockout release waiting", 3'b000, 3'b000);
        tick(1);
        chk("R10 lockout release restore", 3'b001, 3'b100);
    endtask

    // Halt reaches the logic on the same edge the dead-time count would complete.
    task automatic t_collision();
        hi_cmd_n = 3'b111;
        tick(3);
        chk("R7 hi A off", 3'b000, 3'b100);
        hi_cmd_n = 3'b110;
        tick(3);
        halt = 1'b1;
        tick(3);
        chk("R8 halt wins on count edge", 3'b000, 3'b000);
        halt = 1'b0;
        hi_cmd_n = 3'b111;
        lo_cmd = 3'b000;
        tick(DT + 2);
        chk("R8 quiet after collision", 3'b000, 3'b000);
    endtask

    task automatic t_bypass();
        dt_bypass = 1'b1;
        hi_cmd_n = 3'b110;
        lo_cmd = 3'b001;
        tick(2);
        chk("R11 bypass not yet", 3'b000, 3'b000);
        tick(1);
        chk("R11 bypass both on", 3'b001, 3'b001);
        halt = 1'b1;
        tick(3);
        chk("R8 halt over bypass", 3'b000, 3'b000);
        halt = 1'b0;
        tick(3);
        chk("R11 bypass no dead time", 3'b001, 3'b001);
        dt_bypass = 1'b0;
        tick(3);
        chk("R4 priority after bypass", 3'b000, 3'b001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: hi=%b lo=%b expected run to finish", hi_gate, lo_gate);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_refresh();
        t_lo_priority();
        t_restart();
        t_halt_uv();
        t_collision();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule